// File: doc/BRIEF.md
# Video blanking control formatter

This block sits on the parallel side of a serial video link and shapes one pixel word per clock. On the transmit path it picks a data-enable from either a dedicated pin or the enable bit carried with the pixel word. During active video it forwards the colour and control payload, but holds the horizontal and vertical sync values frozen at their last blanking values. During blanking it forwards only a designated set of control bits, with every other payload bit forced low. The designated bits are also forced low on the first and the last pixel of each blanking interval.

Finding the last blanking pixel needs one pixel of look-ahead, so the transmit path has a one-word staging register in front of its output register. A width input narrows the payload from 32 to 24 bits. A pulse flags any enable high time or low time shorter than the allowed minimum. The low-time minimum is larger when the link splits pixels across two lanes.

A small receive path restores the enable output and the held sync values from a recovered link word, one clock after that word arrives.

Top module: `blank_fmt`

## Requirements
- R1: While the effective enable of a pixel is high, out_de is 1 and out_data equals the input payload under the width mask.
- R2: While out_de is 1, out_hs and out_vs show the sync values of the most recent blanking pixel (0 if none since reset). While out_de is 0, they show the pixel's own sync inputs.
- R3: On a blanking pixel that is neither the first nor the last of its interval, out_data equals the input payload ANDed with CTL_MASK (default 0x0F000303) and the width mask.
- R4: On the first blanking pixel (previous pixel active) and on the last blanking pixel (next pixel active), out_data is all zero. A blanking pixel that directly follows reset does not count as a first pixel.
- R5: With de_sel=1 the effective enable is in_de. With de_sel=0 it is de_ext, and in_de has no effect on any output.
- R6: With mode24=1, out_data bits [31:24] are always 0. With mode24=0, all 32 bits follow R1 and R3.
- R7: The outputs for a pixel presented before clock edge k are visible after edge k+1. During and just after reset, every output is 0.
- R8: de_short pulses for one cycle, together with the first pixel that follows it, when an enable high run was shorter than 2 pixels.
- R9: de_short pulses likewise after an enable low run shorter than 2 pixels, or shorter than 4 pixels when split_mode=1. A low run that began at reset is never flagged.
- R10: rx_out_de and rx_out_data equal rx_de and rx_data one cycle later. rx_out_hs and rx_out_vs follow rx_hs and rx_vs while rx_de is 0, and hold their last blanking values while rx_de is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| de_sel | input | 1 | 1: enable taken from in_de; 0: enable taken from de_ext |
| de_ext | input | 1 | Dedicated enable input |
| mode24 | input | 1 | 1: 24-bit payload; 0: 32-bit payload |
| split_mode | input | 1 | 1: dual-lane split, low-time minimum of 4 pixels |
| in_data | input | DATA_W | Pixel payload (colour and control bits) |
| in_hs | input | 1 | Horizontal sync of the pixel |
| in_vs | input | 1 | Vertical sync of the pixel |
| in_de | input | 1 | Enable bit carried with the pixel word |
| out_data | output | DATA_W | Formatted payload |
| out_hs | output | 1 | Formatted horizontal sync |
| out_vs | output | 1 | Formatted vertical sync |
| out_de | output | 1 | Effective enable of the output pixel |
| de_short | output | 1 | Minimum-width violation pulse |
| rx_data | input | DATA_W | Recovered link payload |
| rx_hs | input | 1 | Recovered horizontal sync |
| rx_vs | input | 1 | Recovered vertical sync |
| rx_de | input | 1 | Recovered enable |
| rx_out_data | output | DATA_W | Receive payload output |
| rx_out_hs | output | 1 | Receive horizontal sync output |
| rx_out_vs | output | 1 | Receive vertical sync output |
| rx_out_de | output | 1 | Rebuilt enable output |

## Verification
Every transmit result (payload, syncs, enable and the violation pulse) is due two clocks after its pixel is presented. Receive results are due one clock after. The bench drives pixel j on the falling edge j and, on the same falling edge, samples the transmit outputs of pixel j-2 and the receive outputs of pixel j-1. The expected words come from a model of the requirements that uses the previous and the next enable of each pixel. A dedicated latency check confirms that out_de is still low one falling edge after the first active pixel is driven and high on the next one.

// File: rtl/blank_fmt.sv
module blank_fmt #(
  parameter int DATA_W       = 32,
  parameter int NARROW_W     = 24,
  parameter int CNT_W        = 3,
  parameter int MIN_HI       = 2,
  parameter int MIN_LO       = 2,
  parameter int MIN_LO_SPLIT = 4,
  parameter logic [DATA_W-1:0] CTL_MASK = DATA_W'(32'h0F00_0303)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de_sel,
  input  logic              de_ext,
  input  logic              mode24,
  input  logic              split_mode,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_hs,
  input  logic              in_vs,
  input  logic              in_de,
  output logic [DATA_W-1:0] out_data,
  output logic              out_hs,
  output logic              out_vs,
  output logic              out_de,
  output logic              de_short,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_hs,
  input  logic              rx_vs,
  input  logic              rx_de,
  output logic [DATA_W-1:0] rx_out_data,
  output logic              rx_out_hs,
  output logic              rx_out_vs,
  output logic              rx_out_de
);
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'((64'd1 << NARROW_W) - 64'd1);
  localparam logic [CNT_W-1:0]  HI_MIN      = CNT_W'(MIN_HI);
  localparam logic [CNT_W-1:0]  LO_MIN      = CNT_W'(MIN_LO);
  localparam logic [CNT_W-1:0]  LO_MIN_SPL  = CNT_W'(MIN_LO_SPLIT);

  logic              s1_de, s1_hs, s1_vs;
  logic [DATA_W-1:0] s1_data;
  logic              prev_de, hold_hs, hold_vs;
  logic [CNT_W-1:0]  run_cnt;
  logic              rx_hold_hs, rx_hold_vs;

  wire              de_now   = de_sel ? in_de : de_ext;
  wire [DATA_W-1:0] wmask    = mode24 ? NARROW_MASK : '1;
  wire              toggled  = s1_de != prev_de;
  wire              edge_pix = !s1_de && (prev_de || de_now);
  wire [CNT_W-1:0]  lo_min   = split_mode ? LO_MIN_SPL : LO_MIN;
  wire              too_short = toggled && (prev_de ? (run_cnt < HI_MIN) : (run_cnt < lo_min));

  wire [DATA_W-1:0] blank_data = edge_pix ? '0 : (s1_data & CTL_MASK & wmask);
  wire [DATA_W-1:0] next_data  = s1_de ? (s1_data & wmask) : blank_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_de   <= 1'b0;
      s1_hs   <= 1'b0;
      s1_vs   <= 1'b0;
      s1_data <= '0;
    end else begin
      s1_de   <= de_now;
      s1_hs   <= in_hs;
      s1_vs   <= in_vs;
      s1_data <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_de <= 1'b0;
      run_cnt <= '1;
      hold_hs <= 1'b0;
      hold_vs <= 1'b0;
    end else begin
      prev_de <= s1_de;
      if (toggled)          run_cnt <= CNT_W'(1);
      else if (run_cnt != '1) run_cnt <= run_cnt + CNT_W'(1);
      if (!s1_de) begin
        hold_hs <= s1_hs;
        hold_vs <= s1_vs;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_hs   <= 1'b0;
      out_vs   <= 1'b0;
      out_de   <= 1'b0;
      de_short <= 1'b0;
    end else begin
      out_data <= next_data;
      out_hs   <= s1_de ? hold_hs : s1_hs;
      out_vs   <= s1_de ? hold_vs : s1_vs;
      out_de   <= s1_de;
      de_short <= too_short;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_out_data <= '0;
      rx_out_de   <= 1'b0;
      rx_out_hs   <= 1'b0;
      rx_out_vs   <= 1'b0;
      rx_hold_hs  <= 1'b0;
      rx_hold_vs  <= 1'b0;
    end else begin
      rx_out_data <= rx_data;
      rx_out_de   <= rx_de;
      rx_out_hs   <= rx_de ? rx_hold_hs : rx_hs;
      rx_out_vs   <= rx_de ? rx_hold_vs : rx_vs;
      if (!rx_de) begin
        rx_hold_hs <= rx_hs;
        rx_hold_vs <= rx_vs;
      end
    end
  end
endmodule

// File: rtl/blank_fmt_chk.sv
module blank_fmt_chk #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 24,
  parameter logic [DATA_W-1:0] CTL_MASK = DATA_W'(32'h0F00_0303)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode24,
  input logic [DATA_W-1:0] out_data,
  input logic              out_hs,
  input logic              out_vs,
  input logic              out_de,
  input logic              de_short,
  input logic              rx_de,
  input logic              rx_out_de
);
  // R3
  blank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> ((out_data & ~CTL_MASK) == '0));

  // R4
  first_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_de) |-> (out_data == '0));

  // R6
  narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode24 |=> (out_data[DATA_W-1:NARROW_W] == '0));

  // R2
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_de && $past(out_de)) |-> ($stable(out_hs) && $stable(out_vs)));

  // R8
  short_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_de && $past(out_de) && !$past(out_de, 2)) |-> de_short);

  // R10
  rx_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_out_de == $past(rx_de)));
endmodule

bind blank_fmt blank_fmt_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .CTL_MASK(CTL_MASK)) u_chk (.*);

// File: tb/sim_blank_fmt.sv
module sim_blank_fmt;
  localparam logic [31:0] CTLM = 32'h0F00_0303;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic de_sel = 1'b1, de_ext = 1'b0, mode24 = 1'b0, split_mode = 1'b0;
  logic [31:0] in_data = '0;
  logic in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0;
  logic [31:0] out_data;
  logic out_hs, out_vs, out_de, de_short;
  logic [31:0] rx_data = '0;
  logic rx_hs = 1'b0, rx_vs = 1'b0, rx_de = 1'b0;
  logic [31:0] rx_out_data;
  logic rx_out_hs, rx_out_vs, rx_out_de;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [31:0] pd [64];
  logic ph [64], pv [64], pde [64];

  blank_fmt u0 (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    wait (cyc == 150000);
    errors++; checks++;
    $display("FAIL watchdog: act=hung exp=done");
    summary();
    $finish;
  end

  task automatic do_reset();
    rst_n = 1'b0; in_data = '0; in_hs = 0; in_vs = 0; in_de = 0; de_ext = 0;
    rx_data = '0; rx_hs = 0; rx_vs = 0; rx_de = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic fill(int seed, int n);
    for (int i = 0; i < n; i++) begin
      pd[i] = 32'(i) * 32'h9E37_79B1 + 32'(seed) * 32'h7F4A_7C15;
      ph[i] = (((i + seed) >> 1) & 1) != 0;
      pv[i] = (((i + seed) >> 2) & 1) != 0;
      pde[i] = 1'b0;
    end
  endtask

  task automatic set_de(int from, int len);
    for (int i = from; i < from + len; i++) pde[i] = 1'b1;
  endtask

  // drives pde as the effective enable; the unused enable source gets its inverse
  task automatic run_stream(int n, string tag);
    logic hold_h, hold_v;
    logic [31:0] wm;
    hold_h = 0; hold_v = 0;
    wm = mode24 ? 32'h00FF_FFFF : 32'hFFFF_FFFF;
    do_reset();
    for (int j = 0; j < n + 2; j++) begin
      int k;
      @(negedge clk);
      if (j >= 2 && j - 2 <= n - 2) begin
        int i;
        logic e, pr, nx, sh, eh, ev;
        logic [31:0] ed;
        i = j - 2;
        e = pde[i];
        pr = (i > 0) ? pde[i-1] : 1'b0;
        nx = pde[i+1];
        if (e) ed = pd[i] & wm;
        else if (pr || nx) ed = '0;
        else ed = pd[i] & CTLM & wm;
        eh = e ? hold_h : ph[i];
        ev = e ? hold_v : pv[i];
        if (!e) begin hold_h = ph[i]; hold_v = pv[i]; end
        sh = 1'b0;
        if (i > 0 && e != pr) begin
          int len, m;
          bit from_reset;
          len = 0; m = i - 1; from_reset = 0;
          while (m >= 0 && pde[m] == pr) begin len++; m--; end
          if (m < 0 && !pr) from_reset = 1;
          if (!from_reset)
            sh = pr ? (len < 2) : (len < (split_mode ? 4 : 2));
        end
        check(tag, {out_de, out_hs, out_vs, de_short, out_data}, {e, eh, ev, sh, ed});
      end
      k = (j < n) ? j : n - 1;
      in_data = pd[k]; in_hs = ph[k]; in_vs = pv[k];
      if (de_sel) begin in_de = pde[k]; de_ext = ~pde[k]; end
      else begin de_ext = pde[k]; in_de = ~pde[k]; end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_data = '1; in_hs = 1; in_vs = 1; in_de = 1; de_ext = 1;
    rx_data = '1; rx_hs = 1; rx_vs = 1; rx_de = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    check("R7 reset", {out_de, out_hs, out_vs, de_short, out_data}, '0);
    check("R7 reset rx", {rx_out_de, rx_out_hs, rx_out_vs, 1'b0, rx_out_data}, '0);
  endtask

  task automatic t_latency();
    de_sel = 1; mode24 = 0; split_mode = 0;
    do_reset();
    @(negedge clk) in_de = 1; in_data = 32'h1234_5678;
    @(negedge clk);
    check("R7 latency early", {35'd0, out_de}, 36'd0);
    @(negedge clk);
    check("R7 latency due", {out_de, 3'b000, out_data}, {1'b1, 3'b000, 32'h1234_5678});
  endtask

  task automatic t_main();
    de_sel = 1; mode24 = 0; split_mode = 0;
    fill(3, 26);
    set_de(5, 4); set_de(15, 3); set_de(24, 2);
    run_stream(26, "R1 R2 R3 R4 active/blank");
  endtask

  task automatic t_ext_de();
    de_sel = 0; mode24 = 0; split_mode = 0;
    fill(11, 24);
    set_de(3, 5); set_de(13, 6);
    run_stream(24, "R5 dedicated enable");
  endtask

  task automatic t_narrow();
    de_sel = 1; mode24 = 1; split_mode = 0;
    fill(7, 24);
    set_de(4, 3); set_de(12, 5);
    run_stream(24, "R6 24-bit");
    mode24 = 0;
  endtask

  task automatic t_short(bit spl, string tag);
    de_sel = 1; mode24 = 0; split_mode = spl;
    fill(5, 22);
    set_de(4, 1); set_de(8, 2); set_de(11, 3); set_de(17, 1);
    run_stream(22, tag);
    split_mode = 0;
  endtask

  task automatic t_rx();
    logic e [20], h [20], v [20];
    logic [31:0] d [20];
    logic hh, hv;
    hh = 0; hv = 0;
    for (int i = 0; i < 20; i++) begin
      e[i] = (i >= 4 && i < 9) || (i >= 13 && i < 17);
      h[i] = (i % 3) == 0;
      v[i] = (i % 5) < 2;
      d[i] = 32'hA5A5_0000 + 32'(i * 77);
    end
    do_reset();
    for (int j = 0; j < 21; j++) begin
      @(negedge clk);
      if (j >= 1) begin
        int i;
        logic xh, xv;
        i = j - 1;
        xh = e[i] ? hh : h[i];
        xv = e[i] ? hv : v[i];
        if (!e[i]) begin hh = h[i]; hv = v[i]; end
        check("R10 receive", {rx_out_de, rx_out_hs, rx_out_vs, 1'b0, rx_out_data},
              {e[i], xh, xv, 1'b0, d[i]});
      end
      if (j < 20) begin
        rx_de = e[j]; rx_hs = h[j]; rx_vs = v[j]; rx_data = d[j];
      end
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_main();
    t_ext_de();
    t_narrow();
    t_short(1'b0, "R8 R9 short runs");
    t_short(1'b1, "R9 split short low");
    t_rx();
    summary();
    $finish;
  end
endmodule